// File: doc/BRIEF.md
# Serial Diagnostic and Control Slave Port

This block is the serial slave port of a dual-channel switch controller. A host controller selects it with an active-low chip select, clocks it with a serial clock, and exchanges one byte per frame in both directions at once. While the host shifts a command byte in, the block shifts out the latched fault flags captured when the frame opened. Because the serial output always carries the bit that has sat longest in the shift register, several of these ports can be chained in series and driven by one longer frame.

All three serial inputs are sampled in the system clock domain through two-flop synchronisers, and edges are found by comparing registered samples. The system clock must run at least four times faster than the serial clock. When a frame closes cleanly, the block stores the received byte in its control register, pulses a flag-clear strobe for one cycle, and clears the sticky fault flags. A frame with a bad bit count or a clock-phase violation is thrown away. Committing the sleep code returns the control register to its default value.

Top module: `diag_spi_slave`

## Requirements
- R1: Bits move most significant bit first. The port samples SI on each falling SCLK edge and updates SO on each rising SCLK edge, so the host reads each bit while SCLK is high.
- R2: While CS_N is high, activity on SCLK and SI has no effect, so_oe is 0 and so_out is 0.
- R3: A falling CS_N edge loads the latched fault flags into the shift register, and flag bit 7 appears on so_out before the first SCLK edge. so_oe is 1 from then until CS_N rises.
- R4: On a valid frame end, ctrl_out takes the last 8 bits received, with the first of those 8 bits at bit 7. flags_clr pulses high for exactly one clock.
- R5: A frame is valid only if the number of falling SCLK edges seen while CS_N was low is a nonzero multiple of 8. Any other count leaves ctrl_out unchanged, gives no flags_clr pulse and keeps the flags.
- R6: If SCLK is high at the falling or at the rising CS_N edge, the frame is not committed and the flags are kept.
- R7: In a 16-bit frame, the last 8 bits read from so_out equal the first 8 bits sent on SI.
- R8: Bit i of fault_set sets flag i, which stays set until a valid frame end clears it. A fault that arrives in the same cycle as a clear wins over the clear.
- R9: Committing the byte 0xA5 is a sleep command. ctrl_out returns to its default 0x00 and the flags are cleared.
- R10: After reset, ctrl_out is 0x00, so_oe is 0, so_out is 0 and flags_clr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| si | input | 1 | Serial data in, MSB first |
| fault_set | input | 8 | One set pulse per fault flag |
| so_out | output | 1 | Serial data out, 0 when disabled |
| so_oe | output | 1 | Output enable for the SO pad driver |
| ctrl_out | output | 8 | Committed control byte |
| flags_clr | output | 1 | One-cycle pulse on each committed frame |

## Verification
On every cycle, the checker enforces these rules: ctrl_out never changes without a flags_clr pulse, flags_clr never lasts two cycles, a flag falls only right after a clear, and a fault input always leaves its flag set. The output enable may rise only after chip select has been seen low and may fall only after it has been seen high, and so_out stays quiet while disabled. Only the bench scenarios can show that bits are ordered correctly on SO and in ctrl_out, and that the daisy-chain pass-through works. They also show that bad bit counts and clock-phase violations are rejected, and that the sleep code returns the defaults. These depend on whole framed sequences, not on single-cycle relations.

// File: rtl/diag_spi_pkg.sv
package diag_spi_pkg;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_SHIFT = 1'b1
    } phase_e;

    function automatic logic [7:0] bump_count(input logic [7:0] cnt, input logic [7:0] last);
        return (cnt == last) ? 8'd0 : cnt + 8'd1;
    endfunction

endpackage

// File: rtl/diag_spi_sync.sv
module diag_spi_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_in,
    output logic [N-1:0] sync_out
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], raw_in[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
            else        chain_q <= chain_d;
        end

        assign sync_out[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/diag_spi_flags.sv
module diag_spi_flags #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] fault_set,
    input  logic         clr,
    output logic [W-1:0] flags
);

    logic [W-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (clr) flags_d = '0;
        flags_d = flags_d | fault_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

endmodule

// File: rtl/diag_spi_frame.sv
module diag_spi_frame
    import diag_spi_pkg::*;
#(
    parameter int           W          = 8,
    parameter logic [W-1:0] CTRL_RST   = '0,
    parameter logic [W-1:0] SLEEP_CODE = 8'hA5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_lvl,
    input  logic         sclk_lvl,
    input  logic         si_lvl,
    input  logic [W-1:0] flags,
    output logic         so_out,
    output logic         so_oe,
    output logic [W-1:0] ctrl,
    output logic         clr
);

    localparam int CW = $clog2(W);
    localparam logic [7:0] LAST = 8'(W - 1);

    typedef struct packed {
        phase_e       ph;
        logic [W-1:0] sh;
        logic [CW-1:0] cnt;
        logic         seen;
        logic         err;
        logic         so;
        logic [W-1:0] ctrl;
        logic         clr;
        logic         cs_p;
        logic         sclk_p;
    } st_t;

    localparam st_t RST_ST = '{
        ph: PH_IDLE, sh: '0, cnt: '0, seen: 1'b0, err: 1'b0, so: 1'b0,
        ctrl: CTRL_RST, clr: 1'b0, cs_p: 1'b1, sclk_p: 1'b0
    };

    st_t d, q;
    logic cs_fall, cs_rise, sclk_fall, sclk_rise, frame_ok, is_sleep;
    logic [7:0] cnt_ext;

    always_comb begin
        cs_fall   = q.cs_p & ~cs_lvl;
        cs_rise   = ~q.cs_p & cs_lvl;
        sclk_fall = q.sclk_p & ~sclk_lvl;
        sclk_rise = ~q.sclk_p & sclk_lvl;
        frame_ok  = !q.err && !sclk_lvl && q.seen && (q.cnt == '0);
        is_sleep  = (q.sh == SLEEP_CODE);
        cnt_ext   = bump_count(8'(q.cnt), LAST);

        d        = q;
        d.clr    = 1'b0;
        d.cs_p   = cs_lvl;
        d.sclk_p = sclk_lvl;

        case (q.ph)
            PH_IDLE: begin
                if (cs_fall) begin
                    d.ph   = PH_SHIFT;
                    d.sh   = flags;
                    d.so   = flags[W-1];
                    d.cnt  = '0;
                    d.seen = 1'b0;
                    d.err  = sclk_lvl;
                end
            end
            PH_SHIFT: begin
                if (cs_rise) begin
                    d.ph = PH_IDLE;
                    d.so = 1'b0;
                    if (frame_ok) begin
                        d.clr = 1'b1;
                        if (is_sleep) begin
                            d.ctrl = CTRL_RST;
                            d.sh   = '0;
                        end else begin
                            d.ctrl = q.sh;
                        end
                    end
                end else begin
                    if (sclk_fall) begin
                        d.sh   = {q.sh[W-2:0], si_lvl};
                        d.cnt  = cnt_ext[CW-1:0];
                        d.seen = 1'b1;
                    end
                    if (sclk_rise) begin
                        d.so = q.sh[W-1];
                    end
                end
            end
            default: d = RST_ST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_ST;
        else        q <= d;
    end

    assign so_oe  = (q.ph == PH_SHIFT);
    assign so_out = q.so & (q.ph == PH_SHIFT);
    assign ctrl   = q.ctrl;
    assign clr    = q.clr;

endmodule

// File: rtl/diag_spi_slave.sv
module diag_spi_slave #(
    parameter int                 FRAME_W    = 8,
    parameter int                 SYNC_DEPTH = 2,
    parameter logic [FRAME_W-1:0] CTRL_RST   = '0,
    parameter logic [FRAME_W-1:0] SLEEP_CODE = 8'hA5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               sclk,
    input  logic               si,
    input  logic [FRAME_W-1:0] fault_set,
    output logic               so_out,
    output logic               so_oe,
    output logic [FRAME_W-1:0] ctrl_out,
    output logic               flags_clr
);

    logic [2:0]         pins_sync;
    logic               cs_lvl, sclk_lvl, si_lvl;
    logic [FRAME_W-1:0] flags_q;

    diag_spi_sync #(
        .N       (3),
        .STAGES  (SYNC_DEPTH),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   ({si, sclk, cs_n}),
        .sync_out (pins_sync)
    );

    assign cs_lvl   = pins_sync[0];
    assign sclk_lvl = pins_sync[1];
    assign si_lvl   = pins_sync[2];

    diag_spi_flags #(.W(FRAME_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_set (fault_set),
        .clr       (flags_clr),
        .flags     (flags_q)
    );

    diag_spi_frame #(
        .W          (FRAME_W),
        .CTRL_RST   (CTRL_RST),
        .SLEEP_CODE (SLEEP_CODE)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_lvl   (cs_lvl),
        .sclk_lvl (sclk_lvl),
        .si_lvl   (si_lvl),
        .flags    (flags_q),
        .so_out   (so_out),
        .so_oe    (so_oe),
        .ctrl     (ctrl_out),
        .clr      (flags_clr)
    );

endmodule

// File: rtl/diag_spi_slave_chk.sv
module diag_spi_slave_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] fault_set,
    input logic [W-1:0] flags_q,
    input logic         flags_clr,
    input logic [W-1:0] ctrl_out,
    input logic         so_out,
    input logic         so_oe,
    input logic         cs_lvl
);

    a_r4_ctrl_with_clr: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_out) |-> flags_clr);

    a_r4_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
        flags_clr |=> !flags_clr);

    a_r8_fault_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_set) |=> ((flags_q & $past(fault_set)) == $past(fault_set)));

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(flags_q) & ~flags_q)) |-> $past(flags_clr));

    a_r2_so_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !so_oe |-> !so_out);

    a_r3_oe_after_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe) |-> $past(!cs_lvl));

    a_r2_oe_off_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(so_oe) |-> $past(cs_lvl));

endmodule

bind diag_spi_slave diag_spi_slave_chk #(.W(FRAME_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_set (fault_set),
    .flags_q   (flags_q),
    .flags_clr (flags_clr),
    .ctrl_out  (ctrl_out),
    .so_out    (so_out),
    .so_oe     (so_oe),
    .cs_lvl    (cs_lvl)
);

// File: tb/diag_spi_slave_bench.sv
`timescale 1ns/1ps
module diag_spi_slave_bench;

    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       si = 1'b0;
    logic [7:0] fault_set = '0;
    logic       so_out, so_oe, flags_clr;
    logic [7:0] ctrl_out;

    int checks = 0;
    int errors = 0;
    int clr_cnt = 0;
    bit done = 0;
    logic [31:0] rx;
    bit oe_all;

    always #2 clk = ~clk;

    diag_spi_slave u_diag_spi_slave (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si),
        .fault_set(fault_set), .so_out(so_out), .so_oe(so_oe),
        .ctrl_out(ctrl_out), .flags_clr(flags_clr)
    );

    always @(posedge clk) if (rst_n && flags_clr) clr_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // bad_start: SCLK high at CS fall; bad_end: SCLK high at CS rise
    task automatic xfer(input int nbits, input logic [31:0] tx,
                        input bit bad_start, input bit bad_end);
        rx = '0;
        oe_all = 1'b1;
        if (bad_start) begin sclk = 1'b1; wait_n(HALF); end
        cs_n = 1'b0;
        wait_n(HALF);
        if (bad_start) begin sclk = 1'b0; wait_n(HALF); end
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b1;
            si = tx[nbits-1-i];
            wait_n(HALF);
            rx[nbits-1-i] = so_out;
            if (!so_oe) oe_all = 1'b0;
            sclk = 1'b0;
            wait_n(HALF);
        end
        if (bad_end) begin sclk = 1'b1; wait_n(HALF); end
        cs_n = 1'b1;
        wait_n(HALF);
        sclk = 1'b0;
        si = 1'b0;
        wait_n(HALF);
    endtask

    task automatic pulse_fault(input logic [7:0] v);
        fault_set = v;
        wait_n(1);
        fault_set = '0;
        wait_n(1);
    endtask

    task automatic t_reset;
        chk("R10 ctrl", ctrl_out, 8'h00);
        chk("R10 oe", so_oe, 1'b0);
        chk("R10 so", so_out, 1'b0);
        chk("R10 clr", flags_clr, 1'b0);
    endtask

    task automatic t_idle_ignored;
        int c0 = clr_cnt;
        bit oe_seen = 0;
        for (int i = 0; i < 10; i++) begin
            sclk = 1'b1; si = i[0]; wait_n(HALF);
            if (so_oe || so_out) oe_seen = 1;
            sclk = 1'b0; wait_n(HALF);
        end
        chk("R2 idle oe/so", oe_seen, 1'b0);
        chk("R2 idle ctrl", ctrl_out, 8'h00);
        chk("R2 idle clr", clr_cnt, c0);
    endtask

    task automatic t_basic;
        int c0;
        pulse_fault(8'h96);
        c0 = clr_cnt;
        xfer(8, 32'h3C, 0, 0);
        chk("R3 flags on SO", rx, 32'h96);
        chk("R3 oe in frame", oe_all, 1'b1);
        chk("R1 R4 ctrl", ctrl_out, 8'h3C);
        chk("R4 clr pulse", clr_cnt, c0 + 1);
        xfer(8, 32'h3C, 0, 0);
        chk("R8 flags cleared", rx, 32'h00);
    endtask

    task automatic t_short;
        int c0;
        pulse_fault(8'h21);
        c0 = clr_cnt;
        xfer(7, 32'h55, 0, 0);
        chk("R5 ctrl kept", ctrl_out, 8'h3C);
        chk("R5 no clr", clr_cnt, c0);
        xfer(8, 32'h3C, 0, 0);
        chk("R5 flags kept", rx, 32'h21);
    endtask

    task automatic t_daisy;
        xfer(16, 32'hC35A, 0, 0);
        chk("R7 pass-through", rx[7:0], 8'hC3);
        chk("R7 head flags", rx[15:8], 8'h00);
        chk("R7 ctrl last byte", ctrl_out, 8'h5A);
    endtask

    task automatic t_bad_phase;
        int c0;
        pulse_fault(8'h04);
        c0 = clr_cnt;
        xfer(8, 32'h11, 0, 1);
        chk("R6 end ctrl", ctrl_out, 8'h5A);
        chk("R6 end clr", clr_cnt, c0);
        xfer(7, 32'h22, 1, 0);
        chk("R6 start ctrl", ctrl_out, 8'h5A);
        chk("R6 start clr", clr_cnt, c0);
        xfer(8, 32'h5A, 0, 0);
        chk("R6 flags kept", rx, 32'h04);
    endtask

    task automatic t_priority;
        pulse_fault(8'h08);
        fault_set = 8'h40;
        xfer(8, 32'h77, 0, 0);
        fault_set = '0;
        wait_n(2);
        chk("R8 frame flags", rx, 32'h48);
        xfer(8, 32'h77, 0, 0);
        chk("R8 fault over clear", rx, 32'h40);
    endtask

    task automatic t_sleep;
        chk("R9 pre ctrl", ctrl_out, 8'h77);
        pulse_fault(8'h02);
        xfer(8, 32'hA5, 0, 0);
        chk("R9 ctrl default", ctrl_out, 8'h00);
        xfer(8, 32'h00, 0, 0);
        chk("R9 flags cleared", rx, 32'h00);
    endtask

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(5);
        t_reset();
        t_idle_ignored();
        t_basic();
        t_short();
        t_daisy();
        t_bad_phase();
        t_priority();
        t_sleep();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule